// File: doc/BRIEF.md
# Compartment and Security Access Filter

The filter decides, for every transaction aimed at one of a bank of peripherals, whether the transaction may proceed. Each request carries a peripheral index, the requester's compartment identifier (CID), a secure attribute and a privileged attribute. The filter looks up a 32-bit configuration word for the addressed peripheral. It also looks up that peripheral's secure and privileged bits, which are packed 32 peripherals to a register, and the peripheral's semaphore state, which is held in a neighbouring semaphore block. It registers a single grant flag one cycle after the request strobe.

The checks run in a fixed order. An index beyond the entry count is refused. If filtering and semaphore mode are both on, the static CID is ignored: the requester must appear in the whitelist and must currently own the semaphore. If only filtering is on, a static CID of zero admits every compartment and any other value admits only that compartment. The secure and privileged bits are checked last.

A small read port returns the packed security and privilege registers and a read-only hardware-configuration word. That word gives three entry counts whose sum is the number of valid indices.

Top module: `periph_access_filter`

## Requirements
- R1: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and is low otherwise. `resp_grant` is never high without `resp_valid`. Both are low after reset.
- R2: A request whose index is equal to or above CNT_A+CNT_B+CNT_C is denied.
- R3: Configuration word bit 0 is filter enable. When it is 0, no CID rule applies.
- R4: When filter enable is 1, bit 1 (semaphore mode) is 0 and bits 6:4 (static CID) are 0, every requester CID passes the CID stage.
- R5: When filter enable is 1, semaphore mode is 0 and the static CID is nonzero, only a requester CID equal to the static CID passes.
- R6: When filter enable and semaphore mode are both 1, the static CID is ignored and the requester needs whitelist bit 16+CID (bits 23:16) of the configuration word set.
- R7: In semaphore mode, access also needs the peripheral's semaphore to be held with an owner CID equal to the requester CID.
- R8: The secure bit for peripheral n is bit n mod 32 of packed register n div 32. When it is set, a non-secure requester is denied and a secure requester passes this stage.
- R9: The privilege bit uses the same packing. When it is set, an unprivileged requester is denied.
- R10: Reading address 0xFEC returns CNT_A in bits 15:0, CNT_B in bits 23:16 and CNT_C in bits 31:24.
- R11: Packed secure register k reads at 0x10+4k and packed privilege register k reads at 0x30+4k. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_idx | input | IDX_W | Target peripheral index |
| req_cid | input | CID_W | Requester compartment |
| req_secure | input | 1 | Requester is secure |
| req_priv | input | 1 | Requester is privileged |
| cfg_words | input | TOTAL*32 | Per-peripheral configuration words, peripheral n at bits 32n+31:32n |
| sec_regs | input | NREG*32 | Packed secure bits |
| priv_regs | input | NREG*32 | Packed privilege bits |
| sem_held | input | TOTAL | Semaphore taken, one bit per peripheral |
| sem_owner | input | TOTAL*CID_W | Semaphore owner CID per peripheral |
| cfg_rd_addr | input | 12 | Read address of the register port |
| cfg_rd_data | output | 32 | Read data, combinational |
| resp_valid | output | 1 | Decision valid |
| resp_grant | output | 1 | Access granted |

## Verification
Random configuration words are drawn with every combination of filter enable and semaphore mode. Static CIDs, whitelists, semaphore owners and security bits are random, and each request has a random CID and random secure and privileged attributes. A bench model names the rule that decided each case, so a mismatch points at the faulty stage. Directed cases cover the boundaries. The last valid index sits in the second packed register, and the first invalid index sits just past it. A semaphore-mode entry is given a matching static CID but no whitelist bit, which separates the semaphore rule from the static rule. A held semaphore is owned by a different CID. The register reads cover both packed banks, the configuration word and an unmapped address.

// File: rtl/periph_access_filter.sv
module periph_access_filter #(
  parameter int CNT_A = 40,
  parameter int CNT_B = 12,
  parameter int CNT_C = 8,
  parameter int IDX_W = 6,
  parameter int CID_W = 3,
  localparam int TOTAL = CNT_A + CNT_B + CNT_C,
  localparam int NREG = (TOTAL + 31) / 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [IDX_W-1:0]       req_idx,
  input  logic [CID_W-1:0]       req_cid,
  input  logic                   req_secure,
  input  logic                   req_priv,
  input  logic [TOTAL*32-1:0]    cfg_words,
  input  logic [NREG*32-1:0]     sec_regs,
  input  logic [NREG*32-1:0]     priv_regs,
  input  logic [TOTAL-1:0]       sem_held,
  input  logic [TOTAL*CID_W-1:0] sem_owner,
  input  logic [11:0]            cfg_rd_addr,
  output logic [31:0]            cfg_rd_data,
  output logic                   resp_valid,
  output logic                   resp_grant
);
  localparam logic [31:0] HWCFG = {8'(CNT_C), 8'(CNT_B), 16'(CNT_A)};

  logic             in_range;
  logic [IDX_W-1:0] sidx;
  logic [31:0]      word, sec_word, priv_word;
  logic [CID_W-1:0] owner;
  logic             f_en, s_en, cid_ok, sec_ok, grant_d;
  int               reg_sel;

  assign in_range = int'(req_idx) < TOTAL;
  assign sidx     = in_range ? req_idx : '0;
  assign reg_sel  = int'(sidx) / 32;
  assign word     = cfg_words[int'(sidx)*32 +: 32];
  assign owner    = sem_owner[int'(sidx)*CID_W +: CID_W];
  assign sec_word = sec_regs[reg_sel*32 +: 32];
  assign priv_word = priv_regs[reg_sel*32 +: 32];
  assign f_en     = word[0];
  assign s_en     = word[1];

  always_comb begin
    if (f_en && s_en)
      cid_ok = word[16 + int'(req_cid)] && sem_held[sidx] && (owner == req_cid);
    else if (f_en && word[6:4] != 3'd0)
      cid_ok = word[6:4] == 3'(req_cid);
    else
      cid_ok = 1'b1;
  end

  assign sec_ok  = (req_secure || !sec_word[sidx[4:0]]) &&
                   (req_priv || !priv_word[sidx[4:0]]);
  assign grant_d = in_range && cid_ok && sec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= req_valid && grant_d;
    end
  end

  always_comb begin
    cfg_rd_data = '0;
    if (cfg_rd_addr == 12'hFEC) cfg_rd_data = HWCFG;
    for (int k = 0; k < NREG; k++) begin
      if (cfg_rd_addr == 12'(16 + 4*k)) cfg_rd_data = sec_regs[k*32 +: 32];
      if (cfg_rd_addr == 12'(48 + 4*k)) cfg_rd_data = priv_regs[k*32 +: 32];
    end
  end
endmodule

// File: rtl/periph_access_filter_chk.sv
module periph_access_filter_chk #(
  parameter int TOTAL = 60,
  parameter int IDX_W = 6,
  parameter int NREG = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [IDX_W-1:0]   req_idx,
  input logic               req_secure,
  input logic [NREG*32-1:0] sec_regs,
  input logic [11:0]        cfg_rd_addr,
  input logic [31:0]        cfg_rd_data,
  input logic               resp_valid,
  input logic               resp_grant
);
  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  // R1
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_grant |-> resp_valid);
  // R2
  oob_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_idx) >= TOTAL) |=> !resp_grant);
  // R8
  nonsec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_idx) < TOTAL && !req_secure &&
     sec_regs[int'(req_idx) % (NREG*32)]) |=> !resp_grant);
  // R10
  hwcfg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_addr == 12'hFEC) |->
      (int'(cfg_rd_data[15:0]) + int'(cfg_rd_data[23:16]) + int'(cfg_rd_data[31:24]) == TOTAL));
endmodule

bind periph_access_filter periph_access_filter_chk #(
  .TOTAL(CNT_A + CNT_B + CNT_C), .IDX_W(IDX_W), .NREG((CNT_A + CNT_B + CNT_C + 31) / 32)
) chk (.*);

// File: tb/tb_periph_access_filter.sv
module tb_periph_access_filter;
  localparam int CNT_A = 40, CNT_B = 12, CNT_C = 8, IDX_W = 6, CID_W = 3;
  localparam int TOTAL = CNT_A + CNT_B + CNT_C;
  localparam int NREG = (TOTAL + 31) / 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_secure = 0, req_priv = 0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [CID_W-1:0] req_cid = '0;
  logic [TOTAL*32-1:0] cfg_words = '0;
  logic [NREG*32-1:0] sec_regs = '0, priv_regs = '0;
  logic [TOTAL-1:0] sem_held = '0;
  logic [TOTAL*CID_W-1:0] sem_owner = '0;
  logic [11:0] cfg_rd_addr = '0;
  logic [31:0] cfg_rd_data;
  logic resp_valid, resp_grant;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  periph_access_filter #(.CNT_A(CNT_A), .CNT_B(CNT_B), .CNT_C(CNT_C), .IDX_W(IDX_W), .CID_W(CID_W)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string exp_rule(int idx, int cid, bit s, bit p, output bit g);
    logic [31:0] w;
    g = 0;
    if (idx >= TOTAL) return "R2";
    w = cfg_words[idx*32 +: 32];
    if (w[0] && w[1]) begin
      if (!w[16+cid]) return "R6";
      if (!sem_held[idx] || int'(sem_owner[idx*CID_W +: CID_W]) != cid) return "R7";
    end else if (w[0] && w[6:4] != 0) begin
      if (int'(w[6:4]) != cid) return "R5";
    end
    if (sec_regs[(idx/32)*32 + idx%32] && !s) return "R8";
    if (priv_regs[(idx/32)*32 + idx%32] && !p) return "R9";
    g = 1;
    if (!w[0]) return "R3";
    if (w[1]) return "R7";
    return (w[6:4] == 0) ? "R4" : "R5";
  endfunction

  task automatic do_req(int idx, int cid, bit s, bit p);
    bit g;
    string r;
    @(negedge clk);
    req_idx = IDX_W'(idx); req_cid = CID_W'(cid); req_secure = s; req_priv = p; req_valid = 1;
    r = exp_rule(idx, cid, s, p, g);
    @(negedge clk);
    req_valid = 0;
    check({r, " R1 valid"}, 32'(resp_valid), 1);
    check(r, 32'(resp_grant), 32'(g));
  endtask

  task automatic rand_cfg();
    for (int n = 0; n < TOTAL; n++) begin
      cfg_words[n*32 +: 32] = $urandom & 32'h00FF_0073;
      sem_held[n] = 1'($urandom);
      sem_owner[n*CID_W +: CID_W] = CID_W'($urandom);
    end
    sec_regs = {$urandom, $urandom} & {$urandom, $urandom};
    priv_regs = {$urandom, $urandom} & {$urandom, $urandom};
  endtask

  initial begin
    void'($urandom(1234));
    #1;
    check("R1 reset valid", 32'(resp_valid), 0);
    check("R1 reset grant", 32'(resp_grant), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", 32'(resp_valid), 0);

    for (int t = 0; t < 40; t++) begin
      rand_cfg();
      for (int k = 0; k < 20; k++)
        do_req(int'($urandom % 64), int'($urandom % 8), 1'($urandom), 1'($urandom));
    end

    cfg_words = '0; sec_regs = '0; priv_regs = '0; sem_held = '0;
    do_req(TOTAL - 1, 5, 0, 0);                    // R3 last valid index
    do_req(TOTAL, 5, 1, 1);                        // R2 first invalid
    do_req(63, 0, 1, 1);                           // R2
    sec_regs[32 + 27] = 1;                         // R8 peripheral 59 -> reg 1 bit 27
    do_req(59, 2, 0, 1);
    do_req(59, 2, 1, 1);
    priv_regs[32 + 27] = 1;                        // R9
    do_req(59, 2, 1, 0);
    cfg_words[7*32 +: 32] = 32'h0000_0001;         // R4 static 0
    do_req(7, 6, 0, 0);
    cfg_words[7*32 +: 32] = 32'h0000_0031;         // R5 static 3
    do_req(7, 3, 0, 0);
    do_req(7, 4, 0, 0);
    cfg_words[7*32 +: 32] = 32'h0000_0033;         // R6 static matches, no whitelist
    sem_held[7] = 1; sem_owner[7*CID_W +: CID_W] = 3;
    do_req(7, 3, 0, 0);
    cfg_words[7*32 +: 32] = 32'h0008_0033;         // R6 whitelist CID3
    do_req(7, 3, 0, 0);
    sem_owner[7*CID_W +: CID_W] = 2;               // R7 wrong owner
    do_req(7, 3, 0, 0);
    sem_held[7] = 0; sem_owner[7*CID_W +: CID_W] = 3;
    do_req(7, 3, 0, 0);                            // R7 not held
    @(negedge clk);
    check("R1 no spurious", 32'(resp_valid), 0);

    sec_regs = 64'hA5A5_0001_1234_5678; priv_regs = 64'h0F0F_F0F0_CAFE_0042;
    cfg_rd_addr = 12'hFEC; #1;
    check("R10 hwcfg", cfg_rd_data, {8'(CNT_C), 8'(CNT_B), 16'(CNT_A)});
    cfg_rd_addr = 12'h010; #1; check("R11 sec0", cfg_rd_data, 32'h1234_5678);
    cfg_rd_addr = 12'h014; #1; check("R11 sec1", cfg_rd_data, 32'hA5A5_0001);
    cfg_rd_addr = 12'h030; #1; check("R11 priv0", cfg_rd_data, 32'hCAFE_0042);
    cfg_rd_addr = 12'h034; #1; check("R11 priv1", cfg_rd_data, 32'h0F0F_F0F0);
    cfg_rd_addr = 12'h018; #1; check("R11 unmapped", cfg_rd_data, 0);
    cfg_rd_addr = 12'hFE8; #1; check("R11 unmapped", cfg_rd_data, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule